// File: doc/BRIEF.md
# Triple Match/Overflow Timer

This block holds three independent counters, each 32 bits wide by default, behind a small word-addressed register port. Every channel has a live count, a reload value and two compare values. A channel counts up or down. It advances on every bus-clock cycle, or only on rising edges of its own external tick line, which is synchronized inside the block. When a channel passes its terminal value it reloads from its reload register and can post a wrap event. When a step lands on either compare value it posts a match event. All nine events collect in one sticky status register. A mask register gates them onto a single registered interrupt line.

Typical use puts one channel in a periodic mode: count and reload are preset to the all-ones value minus (P-1), so the channel wraps every P ticks. A second channel serves as a one-shot: the current count plus a delta is written into the first compare register. A third channel runs free as a time base that software reads at any moment.

The register port is a plain single-cycle port with no back-pressure. A write with `bus_sel` and `bus_wr` high takes effect at the next clock edge. Read data is a combinational function of `bus_addr` in the same cycle.

Top module: `tri_cmp_timer`

## Requirements
- R1: Word address 4n+k selects register k of channel n (0 count, 1 reload, 2 compare A, 3 compare B). Word 12 is control, word 13 is status and word 14 is mask (byte offsets 0x30, 0x34, 0x38). Reads return the addressed register in the same cycle. Unused word 15 reads zero, and control, status and mask read back only their low 12, 9 and 9 bits.
- R2: After reset every register reads zero and `irq` is low.
- R3: A channel whose run bit (control bit 3n) is set and whose source bit (3n+1) is clear moves by one on every clock cycle. A channel with a clear run bit holds its count.
- R4: When counting up, a step from the all-ones value loads the reload value. With count and reload preset to all-ones minus (P-1), the channel reaches the reload value every P ticks. It sets status bit 3n+2 on each wrap when control bit 3n+2 is set.
- R5: When direction bit 9+n is set, the channel counts down. A step from zero loads the reload value and is a wrap in the same way.
- R6: A tick that moves the count onto compare A sets status bit 3n, and a tick that moves it onto compare B sets status bit 3n+1. The status bit is visible after that same clock edge.
- R7: A bus write to a count register wins over a tick in the same cycle. The written value reads back on the next cycle, and writing a count equal to a compare value posts no match.
- R8: Status bits are sticky. A write to the status register clears exactly the bits written as zero and can set none. An event arriving in the same cycle as a clear leaves its bit set.
- R9: `irq` is the OR over all nine bits of status AND mask, registered once. It rises one cycle after the status bit it reflects.
- R10: With source bit 3n+1 set, a channel advances once per rising edge of `ext_tick[n]`. The step appears on the third clock edge after the input rises: two synchronizer stages plus the edge detector.
- R11: With control bit 3n+2 clear, a wrap still reloads the count but sets no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all state is in this domain |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | With bus_sel: write, taken at the next edge |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| ext_tick | input | 3 | Per-channel external tick, asynchronous |
| irq | output | 1 | Registered, masked OR of the status bits |

## Verification
The properties assume that `bus_sel`, `bus_wr` and `bus_addr` are never unknown while the block is out of reset. They also assume that a status-register write is the only bus action able to remove a status bit. The bench drives every bus field from a defined value at each falling edge and never leaves the address floating. It changes the external tick lines only at falling edges and holds each level for several clock cycles, so each edge crosses the synchronizer exactly once. Count values are preset far away from compare values the bench does not intend to hit, so no stray match muddies the sticky-bit checks.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // events per channel and their position inside a channel's 3-bit group
  localparam int unsigned EV_PER_CH = 3;
  localparam int unsigned EV_CMP_A  = 0;
  localparam int unsigned EV_CMP_B  = 1;
  localparam int unsigned EV_WRAP   = 2;

  // control bits inside a channel's 3-bit group
  localparam int unsigned CTL_RUN     = 0;
  localparam int unsigned CTL_EXT     = 1;
  localparam int unsigned CTL_WRAP_EN = 2;

  // register slot within a channel's 4-word window
  typedef enum logic [1:0] {
    SLOT_COUNT = 2'd0,
    SLOT_RELOAD = 2'd1,
    SLOT_CMP_A = 2'd2,
    SLOT_CMP_B = 2'd3
  } ch_slot_e;

  typedef enum logic {
    DIR_UP = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;
endpackage

// File: rtl/tmr_tick_sync.sv
module tmr_tick_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  // STAGES flops for metastability, one more to find the edge
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-1:0], async_in};
  end

  assign rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         use_ext,
  input  logic         ext_rise,
  input  dir_e         dir,
  input  logic         cnt_we,
  input  logic         rld_we,
  input  logic         cma_we,
  input  logic         cmb_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt,
  output logic [W-1:0] rld,
  output logic [W-1:0] cma,
  output logic [W-1:0] cmb,
  output logic         hit_a,
  output logic         hit_b,
  output logic         wrap
);
  logic [W-1:0] cnt_q, rld_q, cma_q, cmb_q;
  logic         tick, at_end, adv;
  logic [W-1:0] stepped, cnt_nxt;

  assign tick    = run & (use_ext ? ext_rise : 1'b1);
  assign at_end  = (dir == DIR_DOWN) ? (cnt_q == '0) : (cnt_q == '1);
  assign stepped = (dir == DIR_DOWN) ? (cnt_q - 1'b1) : (cnt_q + 1'b1);
  assign cnt_nxt = at_end ? rld_q : stepped;
  // a bus write to the count takes the slot of the tick
  assign adv     = tick & ~cnt_we;

  assign wrap  = adv & at_end;
  assign hit_a = adv & (cnt_nxt == cma_q);
  assign hit_b = adv & (cnt_nxt == cmb_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rld_q <= '0;
      cma_q <= '0;
      cmb_q <= '0;
    end else begin
      if (cnt_we)   cnt_q <= wdata;
      else if (adv) cnt_q <= cnt_nxt;
      if (rld_we) rld_q <= wdata;
      if (cma_we) cma_q <= wdata;
      if (cmb_we) cmb_q <= wdata;
    end
  end

  assign cnt = cnt_q;
  assign rld = rld_q;
  assign cma = cma_q;
  assign cmb = cmb_q;
endmodule

// File: rtl/tmr_event_ctl.sv
module tmr_event_ctl #(
  parameter int unsigned NEV = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] set_vec,
  input  logic           sts_we,
  input  logic           msk_we,
  input  logic [NEV-1:0] wdata,
  output logic [NEV-1:0] sts,
  output logic [NEV-1:0] msk,
  output logic           irq
);
  logic [NEV-1:0] sts_q, msk_q, keep;
  logic           irq_q;

  // bits written as zero are dropped; new events are ORed in after
  assign keep = sts_we ? wdata : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      msk_q <= '0;
      irq_q <= 1'b0;
    end else begin
      sts_q <= (sts_q & keep) | set_vec;
      if (msk_we) msk_q <= wdata;
      irq_q <= |(sts_q & msk_q);
    end
  end

  assign sts = sts_q;
  assign msk = msk_q;
  assign irq = irq_q;
endmodule

// File: rtl/tri_cmp_timer.sv
module tri_cmp_timer
  import tmr_pkg::*;
#(
  parameter int unsigned NCH = 3,
  parameter int unsigned W = 32,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned AW = $clog2(4*NCH+3)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_sel,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [W-1:0]   bus_wdata,
  output logic [W-1:0]   bus_rdata,
  input  logic [NCH-1:0] ext_tick,
  output logic           irq
);
  localparam int unsigned NEV   = EV_PER_CH * NCH;
  localparam int unsigned CTL_W = 4 * NCH;
  localparam int unsigned DIR0  = EV_PER_CH * NCH;
  localparam logic [AW-1:0] CTL_ADDR = AW'(4*NCH);
  localparam logic [AW-1:0] STS_ADDR = AW'(4*NCH+1);
  localparam logic [AW-1:0] MSK_ADDR = AW'(4*NCH+2);

  logic                  bus_we;
  logic [CTL_W-1:0]      ctl_q;
  logic [NCH-1:0][W-1:0] cnt_a, rld_a, cma_a, cmb_a;
  logic [NEV-1:0]        ev_set, sts_q, msk_q;
  ch_slot_e              slot;

  assign bus_we = bus_sel & bus_wr;
  assign slot   = ch_slot_e'(bus_addr[1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 ctl_q <= '0;
    else if (bus_we && bus_addr == CTL_ADDR)    ctl_q <= bus_wdata[CTL_W-1:0];
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic ext_rise, win, hit_a, hit_b, wrap;

    // this channel's 4-word window
    assign win = bus_we && (bus_addr[AW-1:2] == (AW-2)'(g));

    tmr_tick_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .async_in(ext_tick[g]), .rise(ext_rise)
    );

    tmr_channel #(.W(W)) chan_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (ctl_q[EV_PER_CH*g + CTL_RUN]),
      .use_ext (ctl_q[EV_PER_CH*g + CTL_EXT]),
      .ext_rise(ext_rise),
      .dir     (dir_e'(ctl_q[DIR0 + g])),
      .cnt_we  (win && slot == SLOT_COUNT),
      .rld_we  (win && slot == SLOT_RELOAD),
      .cma_we  (win && slot == SLOT_CMP_A),
      .cmb_we  (win && slot == SLOT_CMP_B),
      .wdata   (bus_wdata),
      .cnt     (cnt_a[g]),
      .rld     (rld_a[g]),
      .cma     (cma_a[g]),
      .cmb     (cmb_a[g]),
      .hit_a   (hit_a),
      .hit_b   (hit_b),
      .wrap    (wrap)
    );

    assign ev_set[EV_PER_CH*g + EV_CMP_A] = hit_a;
    assign ev_set[EV_PER_CH*g + EV_CMP_B] = hit_b;
    assign ev_set[EV_PER_CH*g + EV_WRAP]  = wrap & ctl_q[EV_PER_CH*g + CTL_WRAP_EN];
  end

  tmr_event_ctl #(.NEV(NEV)) evt_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_vec(ev_set),
    .sts_we (bus_we && bus_addr == STS_ADDR),
    .msk_we (bus_we && bus_addr == MSK_ADDR),
    .wdata  (bus_wdata[NEV-1:0]),
    .sts    (sts_q),
    .msk    (msk_q),
    .irq    (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == CTL_ADDR)      bus_rdata = {{(W-CTL_W){1'b0}}, ctl_q};
    else if (bus_addr == STS_ADDR) bus_rdata = {{(W-NEV){1'b0}}, sts_q};
    else if (bus_addr == MSK_ADDR) bus_rdata = {{(W-NEV){1'b0}}, msk_q};
    else begin
      for (int i = 0; i < NCH; i++) begin
        if (bus_addr[AW-1:2] == (AW-2)'(i)) begin
          case (slot)
            SLOT_COUNT:  bus_rdata = cnt_a[i];
            SLOT_RELOAD: bus_rdata = rld_a[i];
            SLOT_CMP_A:  bus_rdata = cma_a[i];
            SLOT_CMP_B:  bus_rdata = cmb_a[i];
            default:     bus_rdata = '0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/tri_cmp_timer_chk.sv
module tri_cmp_timer_chk #(
  parameter int unsigned NCH = 3,
  parameter int unsigned W = 32,
  localparam int unsigned AW = $clog2(4*NCH+3),
  localparam int unsigned NEV = 3*NCH,
  localparam int unsigned CTL_W = 4*NCH
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_sel,
  input logic                  bus_wr,
  input logic [AW-1:0]         bus_addr,
  input logic [W-1:0]          bus_wdata,
  input logic                  irq,
  input logic [CTL_W-1:0]      ctl,
  input logic [NEV-1:0]        sts,
  input logic [NEV-1:0]        msk,
  input logic [NCH-1:0][W-1:0] cnt_a
);
  localparam logic [AW-1:0] STS_ADDR = AW'(4*NCH+1);

  assert_irq_tracks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(sts & msk))));

  assert_sticky_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr && bus_addr == STS_ADDR) |=> ((sts & $past(sts)) == $past(sts)));

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    assert_hold_when_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl[3*g] && !(bus_sel && bus_wr && bus_addr == AW'(4*g)))
        |=> (cnt_a[g] == $past(cnt_a[g])));

    assert_count_write_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr == AW'(4*g)) |=> (cnt_a[g] == $past(bus_wdata)));

    assert_wrap_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts[3*g+2]) |-> $past(ctl[3*g+2]));
  end
endmodule

bind tri_cmp_timer tri_cmp_timer_chk #(.NCH(NCH), .W(W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_sel  (bus_sel),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .irq      (irq),
  .ctl      (ctl_q),
  .sts      (sts_q),
  .msk      (msk_q),
  .cnt_a    (cnt_a)
);

// File: tb/tri_cmp_timer_tb_top.sv
`timescale 1ns/1ps
module tri_cmp_timer_tb_top;
  localparam logic [3:0]  A_CTL = 4'd12, A_STS = 4'd13, A_MSK = 4'd14;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = 4'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic [2:0]  ext_tick = 3'b000;
  logic        irq;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tri_cmp_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_tick(ext_tick), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic waitc(input int k);
    repeat (k) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL R2 watchdog: actual %0d cycles expected fewer", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v0, pat;
    repeat (3) @(negedge clk);
    // R2: every register zero out of reset
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), v);
      chk($sformatf("R2 reset word %0d", a), v, 32'd0);
    end
    chk("R2 irq at reset", {31'd0, irq}, 32'd0);
    rst_n = 1'b1;
    waitc(2);

    // R1: channel register read-back sweep
    for (int n = 0; n < 3; n++)
      for (int k = 0; k < 4; k++)
        wr(4'(4*n+k), 32'h5A00_0000 | 32'(n << 12) | 32'(k << 4) | 32'h3);
    for (int n = 0; n < 3; n++)
      for (int k = 0; k < 4; k++) begin
        pat = 32'h5A00_0000 | 32'(n << 12) | 32'(k << 4) | 32'h3;
        rd(4'(4*n+k), v);
        chk($sformatf("R1 ch%0d slot%0d", n, k), v, pat);
      end
    wr(A_MSK, ONES);
    rd(A_MSK, v); chk("R1 mask width", v, 32'h1FF);
    wr(A_MSK, 32'd0);
    wr(A_STS, ONES);
    rd(A_STS, v); chk("R8 status write cannot set", v, 32'd0);
    rd(4'd15, v); chk("R1 unused word", v, 32'd0);
    wr(A_CTL, 32'h0000_0C00);
    rd(A_CTL, v); chk("R1 control read-back", v, 32'h0000_0C00);
    wr(A_CTL, 32'hFFFF_F000);
    rd(A_CTL, v); chk("R1 control width", v, 32'd0);

    // R3: stopped channel holds, running channel steps once per cycle
    wr(4'd0, 32'd100);
    waitc(5);
    rd(4'd0, v); chk("R3 hold while stopped", v, 32'd100);
    wr(4'd0, 32'h0000_1000);
    wr(A_CTL, 32'h1);
    for (int k = 1; k <= 8; k++) begin
      rd(4'd0, v0);
      waitc(k);
      rd(4'd0, v);
      chk($sformatf("R3 free-run delta %0d", k), v - v0, 32'(k));
    end
    // R7: count write overrides the tick in the same cycle
    wr(4'd0, 32'd500);
    rd(4'd0, v); chk("R7 write wins over tick", v, 32'd500);
    waitc(1);
    rd(4'd0, v); chk("R7 resumes after write", v, 32'd501);
    wr(A_CTL, 32'd0);
    wr(A_STS, 32'd0);
    wr(4'd2, 32'd77);
    wr(4'd0, 32'd77);
    waitc(2);
    rd(A_STS, v); chk("R7 write onto compare posts nothing", v, 32'd0);

    // R4 / R11: periodic wrap sweep, wrap status on and off
    for (int oe = 0; oe < 2; oe++)
      for (int p = 1; p <= 6; p++) begin
        pat = ONES - 32'(p - 1);
        wr(A_CTL, 32'd0);
        wr(A_STS, 32'd0);
        wr(4'd0, pat);
        wr(4'd1, pat);
        wr(A_CTL, oe ? 32'h5 : 32'h1);
        waitc(p - 1);
        rd(4'd0, v); chk($sformatf("R4 before wrap P=%0d", p), v, ONES);
        rd(A_STS, v); chk($sformatf("R4 no wrap yet P=%0d", p), v & 32'h4, 32'd0);
        waitc(1);
        rd(4'd0, v); chk($sformatf("R4 reload P=%0d", p), v, pat);
        rd(A_STS, v);
        chk($sformatf("%s P=%0d", oe ? "R4 wrap status" : "R11 wrap status gated", p),
            v & 32'h4, oe ? 32'h4 : 32'd0);
        waitc(p);
        rd(4'd0, v); chk($sformatf("R4 second period P=%0d", p), v, pat);
      end

    // R5: down-counting wrap on channel 1
    wr(A_CTL, 32'd0);
    wr(A_STS, 32'd0);
    wr(4'd4, 32'd2);
    wr(4'd5, 32'd7);
    wr(A_CTL, 32'h0000_0428);
    waitc(2);
    rd(4'd4, v); chk("R5 down to zero", v, 32'd0);
    rd(A_STS, v); chk("R5 no wrap at zero", v, 32'd0);
    waitc(1);
    rd(4'd4, v); chk("R5 reload after zero", v, 32'd7);
    rd(A_STS, v); chk("R5 wrap bit 5", v, 32'h20);

    // R6 / R9: one-shot compare sweep over channels and deltas
    for (int n = 0; n < 3; n++)
      for (int d = 1; d <= 4; d++) begin
        wr(A_CTL, 32'd0);
        wr(A_STS, 32'd0);
        wr(A_MSK, 32'(1 << (3*n)));
        wr(4'(4*n), 32'd1000);
        wr(4'(4*n+2), 32'(1000 + d));
        wr(4'(4*n+3), 32'd5);
        wr(A_CTL, 32'(1 << (3*n)));
        waitc(d - 1);
        rd(A_STS, v); chk($sformatf("R6 ch%0d d=%0d early", n, d), v, 32'd0);
        waitc(1);
        rd(A_STS, v); chk($sformatf("R6 ch%0d d=%0d hit", n, d), v, 32'(1 << (3*n)));
        chk($sformatf("R9 ch%0d d=%0d irq lags", n, d), {31'd0, irq}, 32'd0);
        waitc(1);
        chk($sformatf("R9 ch%0d d=%0d irq up", n, d), {31'd0, irq}, 32'd1);
      end
    wr(A_MSK, 32'd0);

    // R6 compare B and R8 selective clear
    wr(A_CTL, 32'd0);
    wr(A_STS, 32'd0);
    wr(4'd0, 32'd5);
    wr(4'd2, 32'd6);
    wr(4'd3, 32'd7);
    wr(A_CTL, 32'h1);
    wr(A_CTL, 32'd0);
    rd(A_STS, v); chk("R6 both compares", v, 32'h3);
    wr(A_STS, 32'h2);
    rd(A_STS, v); chk("R8 clears only zero bits", v, 32'h2);
    waitc(1);
    chk("R9 irq low with mask clear", {31'd0, irq}, 32'd0);
    // R8 set wins: compare B lands in the same cycle as a full clear
    wr(4'd0, 32'd5);
    wr(A_CTL, 32'h1);
    wr(A_STS, 32'd0);
    rd(A_STS, v); chk("R8 set wins over clear", v, 32'h2);
    wr(A_CTL, 32'd0);

    // R10: external tick on channel 2
    wr(A_STS, 32'd0);
    wr(4'd8, 32'd0);
    wr(A_CTL, 32'h0000_00C0);
    waitc(5);
    rd(4'd8, v); chk("R10 idle without edge", v, 32'd0);
    ext_tick[2] = 1'b1;
    waitc(2);
    rd(4'd8, v); chk("R10 not yet after two edges", v, 32'd0);
    waitc(1);
    rd(4'd8, v); chk("R10 step on third edge", v, 32'd1);
    waitc(5);
    rd(4'd8, v); chk("R10 level gives one step", v, 32'd1);
    ext_tick[2] = 1'b0;
    waitc(4);
    ext_tick[2] = 1'b1;
    waitc(4);
    rd(4'd8, v); chk("R10 second edge", v, 32'd2);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule